// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide Disk Data Port Bridge

This block connects an 8-bit host I/O bus to a disk controller whose data register is 16 bits wide. A single byte register, the pairing latch, sits in the host address map next to the data port. When the host reads the data port, the bridge fetches a whole device word. It hands back the low byte and keeps the high byte in the latch. The next host access, to the latch address, picks up that high byte, so a host word read at the data port returns the full device word in order.

Writes run the other way round. The host first stores the high byte in the latch. Its write to the data port then sends one device word: the latch byte in the upper half and the host byte in the lower half. The other disk register addresses pass straight through as byte accesses. A mode input exchanges host address bits 0 and 3 before decoding. This gives a layout in which the latch sits at the data port address XOR 8.

All strobes and read data are combinational from the host strobes. The only state is the latch, which updates on the clock while a strobe is held.

Top module: `ide_bridge8_16`

## Requirements
- R1: After reset the latch holds 0x00, so a host read of the latch address returns 0x00.
- R2: A host read of the data port (decoded address 0) raises the device read strobe at device address 0 and returns the device low byte to the host while the strobe is held.
- R3: A host read of the data port captures device data bits 15:8 into the latch. A later host read of the latch address (decoded address 1) returns that byte and raises no device strobe.
- R4: A host write to the latch address stores the host byte in the latch and raises no device strobe.
- R5: A host write to the data port raises the device write strobe at device address 0. The device word carries the latch byte in bits 15:8 and the host byte in bits 7:0.
- R6: A host write to the data port with no new latch write beforehand sends the stale latch byte in bits 15:8.
- R7: With the swap mode input high, host address bits 0 and 3 are exchanged before decoding. Host address 8 is then the latch, host address 0 is still the data port, and host address 1 decodes to an unmapped slot.
- R8: Decoded addresses 2 to 7 pass through as byte accesses at the same device address. Write data bits 15:8 are 0x00, reads return device bits 7:0, and the latch is left unchanged.
- R9: A device strobe is only high while chip select and the matching host strobe are high. Decoded addresses 8 to 15 raise no device strobe and read as 0x00.
- R10: If both host strobes are high together, no device strobe is raised and the host read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swap_i | input | 1 | Exchange host address bits 0 and 3 before decoding |
| cs_i | input | 1 | Host chip select |
| haddr_i | input | 4 | Host register address |
| hrd_i | input | 1 | Host read strobe |
| hwr_i | input | 1 | Host write strobe |
| hwdata_i | input | 8 | Host write data |
| hrdata_o | output | 8 | Host read data |
| dev_addr_o | output | 3 | Device register address |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wr_o | output | 1 | Device write strobe |
| dev_wdata_o | output | 16 | Device write word |
| dev_rdata_i | input | 16 | Device read word |

## Verification
Device strobes, address, write word and host read data are combinational. They are due in the same cycle the host strobe is applied. The bench compares them one time step after the falling clock edge on which the driver applies the strobe, before any rising edge. Latch updates are due at the first rising edge inside the strobe. They are therefore checked by a later, separate latch read, or by the high half of a later device write, and never inside the access that loaded the latch.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_DATA  = 2'd1,
    TGT_LATCH = 2'd2,
    TGT_REG   = 2'd3
  } tgt_e;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_bridge_pkg::*;
#(
  parameter int HOST_AW   = 4,
  parameter int DEV_AW    = 3,
  parameter int SWAP_BIT  = 3,
  parameter int DATA_ADDR = 0
) (
  input  logic [HOST_AW-1:0] addr_i,
  input  logic               swap_i,
  output tgt_e               tgt_o,
  output logic [DEV_AW-1:0]  dev_addr_o
);
  localparam int LATCH_ADDR = DATA_ADDR + 1;
  localparam int REG_SPAN   = 2 ** DEV_AW;

  logic [HOST_AW-1:0] dec;

  // optional exchange of bit 0 with SWAP_BIT
  for (genvar i = 0; i < HOST_AW; i++) begin : g_swap
    if (i == 0) begin : g_lo
      assign dec[i] = swap_i ? addr_i[SWAP_BIT] : addr_i[0];
    end else if (i == SWAP_BIT) begin : g_hi
      assign dec[i] = swap_i ? addr_i[0] : addr_i[i];
    end else begin : g_pass
      assign dec[i] = addr_i[i];
    end
  end

  always_comb begin
    if (int'(dec) == DATA_ADDR)       tgt_o = TGT_DATA;
    else if (int'(dec) == LATCH_ADDR) tgt_o = TGT_LATCH;
    else if (int'(dec) < REG_SPAN)    tgt_o = TGT_REG;
    else                              tgt_o = TGT_NONE;
  end

  assign dev_addr_o = dec[DEV_AW-1:0];
endmodule

// File: rtl/ide_byte_latch.sv
module ide_byte_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] cap_d_i,
  input  logic         load_i,
  input  logic [W-1:0] load_d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (cap_i)  q_o <= cap_d_i;
    else if (load_i) q_o <= load_d_i;
  end
endmodule

// File: rtl/ide_bridge8_16.sv
module ide_bridge8_16
  import ide_bridge_pkg::*;
#(
  parameter int HOST_AW   = 4,
  parameter int DEV_AW    = 3,
  parameter int BYTE_W    = 8,
  parameter int SWAP_BIT  = 3,
  parameter int DATA_ADDR = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                swap_i,
  input  logic                cs_i,
  input  logic [HOST_AW-1:0]  haddr_i,
  input  logic                hrd_i,
  input  logic                hwr_i,
  input  logic [BYTE_W-1:0]   hwdata_i,
  output logic [BYTE_W-1:0]   hrdata_o,
  output logic [DEV_AW-1:0]   dev_addr_o,
  output logic                dev_rd_o,
  output logic                dev_wr_o,
  output logic [2*BYTE_W-1:0] dev_wdata_o,
  input  logic [2*BYTE_W-1:0] dev_rdata_i
);
  localparam int WORD_W = 2 * BYTE_W;

  tgt_e              tgt;
  logic              acc_rd, acc_wr;
  logic [BYTE_W-1:0] latch_q;

  ide_addr_decode #(
    .HOST_AW(HOST_AW), .DEV_AW(DEV_AW),
    .SWAP_BIT(SWAP_BIT), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr_i    (haddr_i),
    .swap_i    (swap_i),
    .tgt_o     (tgt),
    .dev_addr_o(dev_addr_o)
  );

  // conflicting strobes are dropped
  assign acc_rd = cs_i && hrd_i && !hwr_i;
  assign acc_wr = cs_i && hwr_i && !hrd_i;

  ide_byte_latch #(.W(BYTE_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (acc_rd && tgt == TGT_DATA),
    .cap_d_i (dev_rdata_i[WORD_W-1:BYTE_W]),
    .load_i  (acc_wr && tgt == TGT_LATCH),
    .load_d_i(hwdata_i),
    .q_o     (latch_q)
  );

  assign dev_rd_o = acc_rd && (tgt == TGT_DATA || tgt == TGT_REG);
  assign dev_wr_o = acc_wr && (tgt == TGT_DATA || tgt == TGT_REG);

  always_comb begin
    if (tgt == TGT_DATA) dev_wdata_o = {latch_q, hwdata_i};
    else                 dev_wdata_o = {{BYTE_W{1'b0}}, hwdata_i};
  end

  always_comb begin
    hrdata_o = '0;
    if (acc_rd) begin
      unique case (tgt)
        TGT_DATA, TGT_REG: hrdata_o = dev_rdata_i[BYTE_W-1:0];
        TGT_LATCH:         hrdata_o = latch_q;
        default:           hrdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ide_bridge_chk.sv
module ide_bridge_chk #(
  parameter int DEV_AW = 3,
  parameter int BYTE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_i,
  input logic                hrd_i,
  input logic                hwr_i,
  input logic [BYTE_W-1:0]   hrdata_o,
  input logic [DEV_AW-1:0]   dev_addr_o,
  input logic                dev_rd_o,
  input logic                dev_wr_o,
  input logic [2*BYTE_W-1:0] dev_wdata_o,
  input logic [2*BYTE_W-1:0] dev_rdata_i,
  input logic [BYTE_W-1:0]   latch_q
);
  a_r9_strobe_needs_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rd_o |-> (cs_i && hrd_i)) and (dev_wr_o |-> (cs_i && hwr_i)));

  a_r10_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_rd_o && dev_wr_o));

  a_r2_read_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rd_o |-> hrdata_o == dev_rdata_i[BYTE_W-1:0]);

  a_r3_capture_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rd_o && dev_addr_o == '0) |=> latch_q == $past(dev_rdata_i[2*BYTE_W-1:BYTE_W]));

  a_r5_word_high_from_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o && dev_addr_o == '0) |-> dev_wdata_o[2*BYTE_W-1:BYTE_W] == latch_q);

  a_r8_reg_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o && dev_addr_o != '0) |-> dev_wdata_o[2*BYTE_W-1:BYTE_W] == '0);

  a_r8_latch_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && (hrd_i || hwr_i)) |=> $stable(latch_q));
endmodule

bind ide_bridge8_16 ide_bridge_chk #(.DEV_AW(DEV_AW), .BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .hrd_i      (hrd_i),
  .hwr_i      (hwr_i),
  .hrdata_o   (hrdata_o),
  .dev_addr_o (dev_addr_o),
  .dev_rd_o   (dev_rd_o),
  .dev_wr_o   (dev_wr_o),
  .dev_wdata_o(dev_wdata_o),
  .dev_rdata_i(dev_rdata_i),
  .latch_q    (latch_q)
);

// File: tb/tb_ide_bridge8_16.sv
module tb_ide_bridge8_16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        swap = 1'b0;
  logic        cs = 1'b0;
  logic [3:0]  haddr = '0;
  logic        hrd = 1'b0;
  logic        hwr = 1'b0;
  logic [7:0]  hwdata = '0;
  logic [7:0]  hrdata;
  logic [2:0]  dev_addr;
  logic        dev_rd, dev_wr;
  logic [15:0] dev_wdata;
  logic [15:0] dev_rdata = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    bit          rd;
    bit          wr;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [7:0]  hr;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_bridge8_16 dut (
    .clk_i(clk), .rst_ni(rst_ni), .swap_i(swap), .cs_i(cs),
    .haddr_i(haddr), .hrd_i(hrd), .hwr_i(hwr), .hwdata_i(hwdata),
    .hrdata_o(hrdata), .dev_addr_o(dev_addr), .dev_rd_o(dev_rd),
    .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  task automatic chk(string tag, bit ok, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares one expected item against outputs in the strobe cycle
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, dev_rd == e.rd, "dev_rd", int'(dev_rd), int'(e.rd));
      chk(e.tag, dev_wr == e.wr, "dev_wr", int'(dev_wr), int'(e.wr));
      if (e.rd || e.wr) chk(e.tag, dev_addr == e.addr, "dev_addr", int'(dev_addr), int'(e.addr));
      if (e.wr) chk(e.tag, dev_wdata == e.wdata, "dev_wdata", int'(dev_wdata), int'(e.wdata));
      chk(e.tag, hrdata == e.hr, "hrdata", int'(hrdata), int'(e.hr));
    end
  end

  task automatic acc(string tag, bit c, logic [3:0] a, bit r, bit w, logic [7:0] wd,
                     logic [15:0] dword, bit e_rd, bit e_wr, logic [2:0] e_addr,
                     logic [15:0] e_wdata, logic [7:0] e_hr);
    exp_t e;
    @(negedge clk);
    cs = c; haddr = a; hrd = r; hwr = w; hwdata = wd; dev_rdata = dword;
    e.tag = tag; e.rd = e_rd; e.wr = e_wr; e.addr = e_addr; e.wdata = e_wdata; e.hr = e_hr;
    q.push_back(e);
    @(negedge clk);
    cs = 1'b0; hrd = 1'b0; hwr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    chk("R9 reset idle", !dev_rd && !dev_wr, "strobes", int'({dev_rd, dev_wr}), 0);

    // R1: latch clears on reset
    acc("R1 reset latch", 1, 4'd1, 1, 0, 8'h00, 16'hFFFF, 0, 0, 3'd0, 16'h0, 8'h00);
    // R2: data read returns low byte
    acc("R2 data read", 1, 4'd0, 1, 0, 8'h00, 16'hA55A, 1, 0, 3'd0, 16'h0, 8'h5A);
    // R3: latch returns captured high byte, no device access
    acc("R3 latch read", 1, 4'd1, 1, 0, 8'h00, 16'h0000, 0, 0, 3'd0, 16'h0, 8'hA5);
    // R4: latch write, no device access
    acc("R4 latch write", 1, 4'd1, 0, 1, 8'h3C, 16'h0000, 0, 0, 3'd0, 16'h0, 8'h00);
    acc("R4 latch readback", 1, 4'd1, 1, 0, 8'h00, 16'h0000, 0, 0, 3'd0, 16'h0, 8'h3C);
    // R5: data write word
    acc("R5 data write", 1, 4'd0, 0, 1, 8'h71, 16'h0000, 0, 1, 3'd0, 16'h3C71, 8'h00);
    // R6: stale latch byte reused
    acc("R6 stale write", 1, 4'd0, 0, 1, 8'h22, 16'h0000, 0, 1, 3'd0, 16'h3C22, 8'h00);
    // R8: register passthrough
    acc("R8 reg write", 1, 4'd7, 0, 1, 8'h90, 16'h0000, 0, 1, 3'd7, 16'h0090, 8'h00);
    acc("R8 reg read", 1, 4'd2, 1, 0, 8'h00, 16'hBEEF, 1, 0, 3'd2, 16'h0, 8'hEF);
    acc("R8 latch kept", 1, 4'd1, 1, 0, 8'h00, 16'h0000, 0, 0, 3'd0, 16'h0, 8'h3C);
    // R9: no chip select, unmapped address
    acc("R9 cs low", 0, 4'd0, 1, 0, 8'h00, 16'h1111, 0, 0, 3'd0, 16'h0, 8'h00);
    acc("R9 unmapped", 1, 4'd12, 1, 0, 8'h00, 16'h1111, 0, 0, 3'd0, 16'h0, 8'h00);
    acc("R9 latch after cs low", 1, 4'd1, 1, 0, 8'h00, 16'h0000, 0, 0, 3'd0, 16'h0, 8'h3C);
    // R10: both strobes
    acc("R10 dual strobe", 1, 4'd0, 1, 1, 8'h55, 16'h7777, 0, 0, 3'd0, 16'h0, 8'h00);
    // R7: swapped decode
    swap = 1'b1;
    acc("R7 swap data read", 1, 4'd0, 1, 0, 8'h00, 16'h1234, 1, 0, 3'd0, 16'h0, 8'h34);
    acc("R7 swap latch at 8", 1, 4'd8, 1, 0, 8'h00, 16'h0000, 0, 0, 3'd0, 16'h0, 8'h12);
    acc("R7 swap addr1 unmapped", 1, 4'd1, 1, 0, 8'h00, 16'h9999, 0, 0, 3'd0, 16'h0, 8'h00);
    acc("R7 swap latch write", 1, 4'd8, 0, 1, 8'hC3, 16'h0000, 0, 0, 3'd0, 16'h0, 8'h00);
    acc("R7 swap data write", 1, 4'd0, 0, 1, 8'h0F, 16'h0000, 0, 1, 3'd0, 16'hC30F, 8'h00);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule